// File: doc/BRIEF.md
# Logic Analyzer Capture Trigger

This block decides the moment a multi-channel logic analyzer should capture. It watches a bus of sampled channels (32 by default). A host sets it up through a byte-wide register write port. Each channel gets a 2-bit level code: must be high, must be low, or ignored. One extra register can add an edge condition on a single chosen channel.

Once armed, the block counts the valid samples on which the whole condition holds. When that count reaches a programmed 16-bit occurrence value, it emits a one-cycle trigger pulse. It then falls back to idle and waits to be armed again. While armed, the configuration is frozen, so a capture in progress cannot be disturbed by a host write.

Top module: `trig_qualifier`

## Requirements
- R1: After reset, `trig_pulse` is low and the block is idle. Every level code is 00, the edge register is 0x00 and the occurrence count is 1, so the first valid sample after arming fires.
- R2: The level code of channel n sits in the register at address 0x40 + n/4, in bits [2*(n mod 4)+1 : 2*(n mod 4)]. Code 01 requires the channel to be 1 and code 10 requires it to be 0.
- R3: Level codes 00 and 11 both leave their channel unconstrained.
- R4: The register at 0x48 holds the edge qualifier. Bits [7:6] give the type: 00 off, 01 rising (0 to 1), 10 falling (1 to 0), 11 either. Bits [5:0] give the channel number. A channel number at or above the channel count can never be met.
- R5: A sample counts only when `smp_valid` is high and every level code and the edge qualifier hold on that same sample. The edge is judged against the most recent earlier valid sample; samples with `smp_valid` low are ignored.
- R6: The occurrence count is at 0x50 (bits 7:0) and 0x51 (bits 15:8). The Nth counting sample after arming makes `trig_pulse` high for exactly one cycle, the cycle after that sample's clock edge.
- R7: An occurrence count of 0 behaves like 1.
- R8: Only a high `arm` in the idle state starts a capture, and it clears the occurrence counter. After the pulse the block is idle and ignores matching samples. A high `arm` while armed does not restart the count.
- R9: Register writes are ignored while the block is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start a capture when idle |
| smp_valid | input | 1 | Qualifies `smp_data` on this cycle |
| smp_data | input | 32 | Sampled channel values, bit n is channel n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| trig_pulse | output | 1 | One-cycle trigger pulse |

## Verification
The level test drives samples that satisfy only one of two qualified channels and then both. This separates the right bit pair and the right register from a neighbouring one, and high from low. The edge patterns run the selected channel through steady, falling and rising steps under each edge type. They also put an invalid sample between two valid ones, which shows whether the previous-sample reference follows the valid strobe.

Occurrence counts of 3, 0 and 258 show whether the low byte, the high byte and the zero case are each decoded. A re-arm in the middle of a count, and writes made while armed, show whether the counter and the configuration are truly held during a capture.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int REG_W = 8;

  localparam logic [REG_W-1:0] ADDR_LVL_BASE = 8'h40;
  localparam logic [REG_W-1:0] ADDR_CNT_BASE = 8'h50;

  localparam logic [1:0] LVL_HIGH = 2'b01;
  localparam logic [1:0] LVL_LOW  = 2'b10;

  localparam logic [1:0] EDGE_OFF  = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_ANY  = 2'b11;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } seq_state_t;

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_lock,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  output logic [2*NUM_CH-1:0]  lvl_codes,
  output logic [REG_W-1:0]     edge_cfg,
  output logic [CNT_W-1:0]     cnt_target
);

  localparam int LVL_REGS  = NUM_CH / 4;
  localparam int CNT_BYTES = CNT_W / REG_W;
  localparam logic [REG_W-1:0] ADDR_EDGE = ADDR_LVL_BASE + REG_W'(LVL_REGS);

  logic wr_ok;
  assign wr_ok = wr_en & ~cfg_lock;

  // level qualifier bytes, four channels per byte
  for (genvar gi = 0; gi < LVL_REGS; gi++) begin : g_lvl
    logic             we;
    logic [REG_W-1:0] q, d;
    assign we = wr_ok && (wr_addr == ADDR_LVL_BASE + REG_W'(gi));
    always_comb d = we ? wr_data : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign lvl_codes[gi*REG_W +: REG_W] = q;
  end

  // edge qualifier byte
  logic             edge_we;
  logic [REG_W-1:0] edge_q, edge_d;
  assign edge_we = wr_ok && (wr_addr == ADDR_EDGE);
  always_comb edge_d = edge_we ? wr_data : edge_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= '0;
    else        edge_q <= edge_d;
  end
  assign edge_cfg = edge_q;

  // occurrence count bytes, little-endian from ADDR_CNT_BASE, resets to 1
  for (genvar gi = 0; gi < CNT_BYTES; gi++) begin : g_cnt
    localparam logic [REG_W-1:0] RST_VAL = (gi == 0) ? REG_W'(1) : '0;
    logic             we;
    logic [REG_W-1:0] q, d;
    assign we = wr_ok && (wr_addr == ADDR_CNT_BASE + REG_W'(gi));
    always_comb d = we ? wr_data : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
    end
    assign cnt_target[gi*REG_W +: REG_W] = q;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> $stable({lvl_codes, edge_cfg, cnt_target}))
    else $error("configuration changed while armed"); // R9

endmodule

// File: rtl/trig_match.sv
module trig_match
  import trig_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [NUM_CH-1:0]   smp_data,
  input  logic [2*NUM_CH-1:0] lvl_codes,
  input  logic [REG_W-1:0]    edge_cfg,
  output logic                hit
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SEL_W = REG_W - 2;

  // previous valid sample, reference for the edge qualifier
  logic [NUM_CH-1:0] prev_q, prev_d;
  logic              seen_q, seen_d;

  always_comb begin
    prev_d = smp_valid ? smp_data : prev_q;
    seen_d = seen_q | smp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      seen_q <= seen_d;
    end
  end

  // per-channel level qualifiers
  logic [NUM_CH-1:0] lvl_ok;
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    logic [1:0] code;
    assign code = lvl_codes[2*gi +: 2];
    assign lvl_ok[gi] = (code == LVL_HIGH) ?  smp_data[gi] :
                        (code == LVL_LOW)  ? ~smp_data[gi] : 1'b1;
  end

  // edge qualifier
  logic [1:0]       edge_kind;
  logic [SEL_W-1:0] edge_sel;
  logic             sel_ok, cur_bit, prv_bit, edge_ok;

  assign edge_kind = edge_cfg[REG_W-1 -: 2];
  assign edge_sel  = edge_cfg[SEL_W-1:0];
  assign sel_ok    = (int'(edge_sel) < NUM_CH) && seen_q;
  assign cur_bit   = smp_data[edge_sel[IDX_W-1:0]];
  assign prv_bit   = prev_q[edge_sel[IDX_W-1:0]];

  always_comb begin
    unique case (edge_kind)
      EDGE_OFF:  edge_ok = 1'b1;
      EDGE_RISE: edge_ok = sel_ok & ~prv_bit &  cur_bit;
      EDGE_FALL: edge_ok = sel_ok &  prv_bit & ~cur_bit;
      EDGE_ANY:  edge_ok = sel_ok & (prv_bit ^ cur_bit);
    endcase
  end

  assign hit = smp_valid & (&lvl_ok) & edge_ok;

endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             hit,
  input  logic [CNT_W-1:0] cnt_target,
  output logic             armed,
  output logic             trig_pulse
);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, goal;
  logic             pulse_q, pulse_d;

  assign goal    = (cnt_target == '0) ? CNT_W'(1) : cnt_target;
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (arm) begin
          st_d  = ST_ARMED;
          cnt_d = '0;
        end
      end
      ST_ARMED: begin
        if (hit) begin
          if (cnt_inc == goal) begin
            st_d    = ST_IDLE;
            cnt_d   = '0;
            pulse_d = 1'b1;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign armed      = (st_q == ST_ARMED);
  assign trig_pulse = pulse_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse)
    else $error("trigger pulse longer than one cycle"); // R6

  AST_CNT_BELOW_GOAL: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt_q < goal))
    else $error("occurrence counter passed its goal"); // R6

  AST_FIRE_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(hit && armed))
    else $error("pulse without an armed matching sample"); // R5

  AST_IDLE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> !armed)
    else $error("still armed after firing"); // R8

endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
  import trig_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              smp_valid,
  input  logic [NUM_CH-1:0] smp_data,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic              trig_pulse
);

  logic [2*NUM_CH-1:0] lvl_codes;
  logic [REG_W-1:0]    edge_cfg;
  logic [CNT_W-1:0]    cnt_target;
  logic                armed;
  logic                hit;

  trig_cfg_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_lock   (armed),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .lvl_codes  (lvl_codes),
    .edge_cfg   (edge_cfg),
    .cnt_target (cnt_target)
  );

  trig_match #(.NUM_CH(NUM_CH)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .lvl_codes (lvl_codes),
    .edge_cfg  (edge_cfg),
    .hit       (hit)
  );

  trig_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .hit        (hit),
    .cnt_target (cnt_target),
    .armed      (armed),
    .trig_pulse (trig_pulse)
  );

endmodule

// File: tb/trig_qualifier_test.sv
module trig_qualifier_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        arm;
  logic        smp_valid;
  logic [31:0] smp_data;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        trig_pulse;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  trig_qualifier uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .trig_pulse (trig_pulse)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_pulse(input string tag, input logic exp);
    check(trig_pulse === exp, tag, {31'b0, trig_pulse}, {31'b0, exp});
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; arm = 1'b0; smp_valid = 1'b0; smp_data = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic send(input logic [31:0] d);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 9; i++) wr(8'h40 + 8'(i), 8'h00);
    wr(8'h50, 8'h01);
    wr(8'h51, 8'h00);
  endtask

  task automatic t_reset();
    reset_dut();
    chk_pulse("R1 reset pulse low", 1'b0);
    send(32'h0);
    chk_pulse("R8 idle ignores match", 1'b0);
    do_arm();
    send(32'h0);
    chk_pulse("R1 default fires on first sample", 1'b1);
    send(32'h0);
    chk_pulse("R8 idle after fire", 1'b0);
  endtask

  task automatic t_level();
    clear_cfg();
    wr(8'h41, 8'h04);   // ch5 high
    wr(8'h47, 8'h80);   // ch31 low
    do_arm();
    send(32'h0000_0000);
    chk_pulse("R2 ch5 low blocks", 1'b0);
    send(32'hFFFF_FFFF);
    chk_pulse("R2 ch31 high blocks", 1'b0);
    send(32'h0000_0020);
    chk_pulse("R2 both levels met", 1'b1);
  endtask

  task automatic t_dontcare();
    clear_cfg();
    wr(8'h40, 8'h03);   // ch0 code 11
    do_arm();
    send(32'h0);
    chk_pulse("R3 code 11 with ch0=0", 1'b1);
    do_arm();
    send(32'hFFFF_FFFF);
    chk_pulse("R3 code 11 with ch0=1", 1'b1);
  endtask

  task automatic t_edge();
    clear_cfg();
    wr(8'h48, 8'h49);   // rising ch9
    send(32'h0);
    do_arm();
    send(32'h200);
    chk_pulse("R4 rising fires", 1'b1);
    do_arm();
    send(32'h200);
    chk_pulse("R4 rising steady high", 1'b0);
    send(32'h0);
    chk_pulse("R4 rising sees fall", 1'b0);
    send(32'h200);
    chk_pulse("R4 rising second", 1'b1);
    wr(8'h48, 8'h89);   // falling ch9
    do_arm();
    send(32'h0);
    chk_pulse("R4 falling fires", 1'b1);
    wr(8'h48, 8'hC9);   // either edge ch9
    do_arm();
    send(32'h0);
    chk_pulse("R4 either steady", 1'b0);
    send(32'h200);
    chk_pulse("R4 either rise", 1'b1);
    do_arm();
    send(32'h0);
    chk_pulse("R4 either fall", 1'b1);
    // invalid sample between valid ones is not the edge reference
    wr(8'h48, 8'h49);
    do_arm();
    smp_valid = 1'b0; smp_data = 32'h200;
    @(negedge clk);
    chk_pulse("R5 invalid sample ignored", 1'b0);
    send(32'h200);
    chk_pulse("R5 edge vs last valid", 1'b1);
    // level and edge on same sample
    wr(8'h40, 8'h01);   // ch0 high
    do_arm();
    send(32'h0);
    chk_pulse("R5 fall no match", 1'b0);
    send(32'h200);
    chk_pulse("R5 edge without level", 1'b0);
    send(32'h0);
    chk_pulse("R5 fall again", 1'b0);
    send(32'h201);
    chk_pulse("R5 edge and level", 1'b1);
  endtask

  task automatic t_count();
    bit early;
    clear_cfg();
    wr(8'h50, 8'h03);
    do_arm();
    send(32'h0);
    chk_pulse("R6 count 3 first", 1'b0);
    send(32'h0);
    chk_pulse("R6 count 3 second", 1'b0);
    send(32'h0);
    chk_pulse("R6 count 3 third", 1'b1);
    send(32'h0);
    chk_pulse("R8 no pulse after fire", 1'b0);
    do_arm();
    send(32'h0);
    chk_pulse("R8 first of three", 1'b0);
    do_arm();
    send(32'h0);
    chk_pulse("R8 rearm no restart", 1'b0);
    send(32'h0);
    chk_pulse("R8 count kept across arm", 1'b1);
    wr(8'h50, 8'h00);
    do_arm();
    send(32'h0);
    chk_pulse("R7 zero acts as one", 1'b1);
    wr(8'h50, 8'h02);
    wr(8'h51, 8'h01);
    do_arm();
    early = 1'b0;
    for (int i = 0; i < 257; i++) begin
      send(32'h0);
      if (trig_pulse !== 1'b0) early = 1'b1;
    end
    check(!early, "R6 high byte no early fire", {31'b0, early}, 32'h0);
    send(32'h0);
    chk_pulse("R6 fires at 258", 1'b1);
  endtask

  task automatic t_lock();
    clear_cfg();
    do_arm();
    wr(8'h50, 8'h05);
    wr(8'h51, 8'h01);
    wr(8'h40, 8'h02);   // ch0 low, must be ignored
    send(32'h1);
    chk_pulse("R9 writes ignored while armed", 1'b1);
    do_arm();
    send(32'h1);
    chk_pulse("R9 config unchanged", 1'b1);
  endtask

  task automatic t_range();
    clear_cfg();
    wr(8'h48, 8'h68);   // rising on channel 40
    send(32'h0);
    do_arm();
    send(32'hFFFF_FFFF);
    chk_pulse("R4 out-of-range rise", 1'b0);
    send(32'h0);
    chk_pulse("R4 out-of-range fall", 1'b0);
    send(32'hFFFF_FFFF);
    chk_pulse("R4 out-of-range again", 1'b0);
    reset_dut();
    chk_pulse("R1 pulse low after reset", 1'b0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_dontcare();
    t_edge();
    t_count();
    t_lock();
    t_range();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule